// File: doc/BRIEF.md
# Peak-and-Hold Current Regulation Controller

This block is the digital sequencer for one switched load channel that needs a high pull-in current followed by a lower sustaining current, such as a valve or relay coil. It drives the enable of the load switch. It selects which current threshold an external comparator should test against, and it passes the matching current code to the external DAC. Regulation works on a fixed off-time principle. The switch conducts until the comparator reports that the selected threshold has been reached. It is then held off for a programmed interval and switched on again. After every turn-on the comparator result is ignored for a short window, so that switching transients cannot end a conduction interval early.

Four regulation schemes are selectable. In the first, the switch simply follows the command. In the second, the block cycles on the hold threshold only. In the third, one peak hit is followed by hold cycling. In the fourth, the block cycles on the peak threshold for a programmed pull-in time and then changes to hold cycling. All durations are counted in pulses of a one-cycle microsecond tick. The scheme is captured when the command turns on. The off-time is captured at each threshold hit, and the pull-in time is captured at turn-on.

Top module: `pkhold_ctrl`

## Requirements
- R1: With scheme code 00 captured at turn-on, `gate_en` equals `cmd_on` delayed by one clock, and `phase` reads 1 (follow) while the command is high.
- R2: On a turn-on from idle under a regulating scheme (codes 01, 10, 11), `gate_en` rises on the next clock and `phase` reads 2 (blank). Comparator inputs are ignored for 20 ticks after that turn-on and after every re-turn-on that ends an off-time. Conduction lasts at least 21 clocks when the tick is high on every clock.
- R3: When a threshold hit is seen in the conduct phase (`phase` = 3), `gate_en` falls on the next clock and stays low in the rest phase (`phase` = 4) for 100·(code+1) ticks, where code is `off_code` (00 to 11 give 100 to 400). The block then re-enters blank.
- R4: Under scheme 01, `thr_peak_sel` is 0 from turn-on, `thr_code` equals `hd_code`, and only `cmp_hold` can end conduction.
- R5: Under scheme 10, the first conduction uses the peak threshold (`thr_peak_sel` = 1, `thr_code` = `pk_code`). Every conduction after the first hit uses the hold threshold. Within one command-on period the hold selection never reverts to peak.
- R6: Under scheme 11, the peak threshold stays selected until 800 + 400·code ticks after the turn-on clock, where code is `ptime_code` (000 to 111 give 0.8 to 3.6 ms). This timer runs through the off-time intervals. If it expires on the same clock as a peak hit, the rest phase still starts, and the next conduction uses hold.
- R7: A low `cmd_on` returns the block to idle on the next clock: `gate_en` = 0, `phase` = 0, `thr_peak_sel` = 1, and all timers cleared. A new turn-on restarts from the peak selection with a full blanking window.
- R8: Blanking, off-time and pull-in timers advance only on clocks where `tick_us` is high. With no tick, the blank and rest phases are held indefinitely.
- R9: Changes on `mode_sel` while the command stays high have no effect; the scheme captured at turn-on stays in force.
- R10: After reset, `gate_en` = 0, `phase` = 0, `thr_peak_sel` = 1, and `thr_code` equals `pk_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_on | input | 1 | Effective on/off command of the channel |
| tick_us | input | 1 | One-cycle timebase pulse, one per microsecond |
| mode_sel | input | 2 | Regulation scheme: 00 follow, 01 hold only, 10 single peak hit, 11 timed peak |
| pk_code | input | CUR_CW (2) | Peak current code, passed to `thr_code` in peak selection |
| hd_code | input | CUR_CW (2) | Hold current code, passed to `thr_code` in hold selection |
| off_code | input | OFF_CW (2) | Off-time code, 100·(code+1) ticks |
| ptime_code | input | PT_CW (3) | Pull-in time code, 800 + 400·code ticks |
| cmp_peak | input | 1 | Sensed current has reached the peak threshold |
| cmp_hold | input | 1 | Sensed current has reached the hold threshold |
| gate_en | output | 1 | Load switch enable |
| thr_peak_sel | output | 1 | 1 selects the peak threshold, 0 the hold threshold |
| thr_code | output | CUR_CW (2) | Current code of the selected threshold |
| phase | output | 3 | 0 idle, 1 follow, 2 blank, 3 conduct, 4 rest |

## Verification
Under the timed-peak scheme, two events can land on the same clock: the pull-in timer expires, and the peak comparator reports a hit. The bench aligns them deliberately. It gives each conduction a 200-clock length against a 100-tick rest, so the third peak hit falls exactly on tick 800 after turn-on. The recorded run lengths must then show a normal 100-tick rest followed by conductions on the hold threshold and hold code. A design that let either event mask the other would either stay in conduction or return to peak. Blanking against an already-asserted comparator is judged the same way: conduction runs must stay at 21 clocks although the comparator model asserts after 1 or 5.

// File: rtl/phc_pkg.sv
package phc_pkg;

  // Controller phase, visible on the phase output
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_FOLLOW  = 3'd1,
    PH_BLANK   = 3'd2,
    PH_CONDUCT = 3'd3,
    PH_REST    = 3'd4
  } phase_e;

  // Regulation scheme, captured at turn-on
  typedef enum logic [1:0] {
    RM_NONE   = 2'b00,
    RM_HOLD   = 2'b01,
    RM_MINPK  = 2'b10,
    RM_PROGPK = 2'b11
  } regmode_e;

endpackage

// File: rtl/phc_rst_sync.sv
module phc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/phc_span_lut.sv
// Linear code-to-tick-count map: BASE + STEP * code
module phc_span_lut #(
  parameter int BASE = 100,
  parameter int STEP = 100,
  parameter int CW   = 2,
  parameter int W    = 9
) (
  input  logic [CW-1:0] code,
  output logic [W-1:0]  span
);

  assign span = W'(BASE) + W'(STEP) * W'(code);

endmodule

// File: rtl/phc_tick_timer.sv
// Down counter advanced by the timebase tick; expire flags the final tick
module phc_tick_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = tick && (cnt_q == W'(1));

endmodule

// File: rtl/phc_seq.sv
// Phase sequencer and threshold selection
module phc_seq
  import phc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_on,
  input  regmode_e mode_in,
  input  logic     cmp_peak,
  input  logic     cmp_hold,
  input  logic     span_exp,
  input  logic     pt_exp,
  output phase_e   ph_q,
  output logic     use_peak_q,
  output logic     span_load,
  output logic     span_off,
  output logic     pt_load,
  output logic     tmr_clr
);

  phase_e   ph_d;
  logic     use_peak_d;
  regmode_e mode_q;
  regmode_e mode_d;
  logic     mode_en;
  logic     hit;

  assign hit = use_peak_q ? cmp_peak : cmp_hold;

  always_comb begin
    ph_d       = ph_q;
    use_peak_d = use_peak_q;
    mode_d     = mode_q;
    mode_en    = 1'b0;
    span_load  = 1'b0;
    span_off   = 1'b0;
    pt_load    = 1'b0;
    tmr_clr    = 1'b0;

    if (!cmd_on) begin
      ph_d       = PH_IDLE;
      use_peak_d = 1'b1;
      tmr_clr    = 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          mode_d  = mode_in;
          mode_en = 1'b1;
          if (mode_in == RM_NONE) begin
            ph_d = PH_FOLLOW;
          end else begin
            ph_d       = PH_BLANK;
            span_load  = 1'b1;
            use_peak_d = (mode_in != RM_HOLD);
            pt_load    = (mode_in == RM_PROGPK);
          end
        end
        PH_FOLLOW: begin
          ph_d = PH_FOLLOW;
        end
        PH_BLANK: begin
          if (span_exp) begin
            ph_d = PH_CONDUCT;
          end
        end
        PH_CONDUCT: begin
          if (hit) begin
            ph_d      = PH_REST;
            span_load = 1'b1;
            span_off  = 1'b1;
            if (mode_q == RM_MINPK) begin
              use_peak_d = 1'b0;
            end
          end
        end
        PH_REST: begin
          if (span_exp) begin
            ph_d      = PH_BLANK;
            span_load = 1'b1;
          end
        end
        default: begin
          ph_d = PH_IDLE;
        end
      endcase

      // Pull-in time over: fall back to hold whatever the phase
      if (pt_exp && (mode_q == RM_PROGPK) && (ph_q != PH_IDLE)) begin
        use_peak_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      use_peak_q <= 1'b1;
    end else begin
      ph_q       <= ph_d;
      use_peak_q <= use_peak_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_NONE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/pkhold_ctrl.sv
module pkhold_ctrl
  import phc_pkg::*;
#(
  parameter int BLANK_TICKS = 20,
  parameter int OFF_BASE    = 100,
  parameter int OFF_STEP    = 100,
  parameter int PT_BASE     = 800,
  parameter int PT_STEP     = 400,
  parameter int CUR_CW      = 2,
  parameter int OFF_CW      = 2,
  parameter int PT_CW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_on,
  input  logic              tick_us,
  input  logic [1:0]        mode_sel,
  input  logic [CUR_CW-1:0] pk_code,
  input  logic [CUR_CW-1:0] hd_code,
  input  logic [OFF_CW-1:0] off_code,
  input  logic [PT_CW-1:0]  ptime_code,
  input  logic              cmp_peak,
  input  logic              cmp_hold,
  output logic              gate_en,
  output logic              thr_peak_sel,
  output logic [CUR_CW-1:0] thr_code,
  output logic [2:0]        phase
);

  localparam int OFF_MAX  = OFF_BASE + OFF_STEP * ((1 << OFF_CW) - 1);
  localparam int SPAN_MAX = (OFF_MAX > BLANK_TICKS) ? OFF_MAX : BLANK_TICKS;
  localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
  localparam int PT_MAX   = PT_BASE + PT_STEP * ((1 << PT_CW) - 1);
  localparam int PT_W     = $clog2(PT_MAX + 1);
  localparam logic [SPAN_W-1:0] BLANK_LEN = SPAN_W'(BLANK_TICKS);

  logic              rst_n_i;
  regmode_e          mode_e;
  phase_e            ph_q;
  logic              use_peak_q;
  logic              span_load;
  logic              span_off;
  logic              pt_load;
  logic              tmr_clr;
  logic              span_exp;
  logic              pt_exp;
  logic [SPAN_W-1:0] off_len;
  logic [SPAN_W-1:0] span_val;
  logic [PT_W-1:0]   pt_len;

  assign mode_e = regmode_e'(mode_sel);

  phc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  phc_span_lut #(.BASE(OFF_BASE), .STEP(OFF_STEP), .CW(OFF_CW), .W(SPAN_W)) u_off_lut (
    .code (off_code),
    .span (off_len)
  );

  phc_span_lut #(.BASE(PT_BASE), .STEP(PT_STEP), .CW(PT_CW), .W(PT_W)) u_pt_lut (
    .code (ptime_code),
    .span (pt_len)
  );

  // One timer serves both blanking and off-time: they never overlap
  assign span_val = span_off ? off_len : BLANK_LEN;

  phc_tick_timer #(.W(SPAN_W)) u_span_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (tmr_clr),
    .load     (span_load),
    .load_val (span_val),
    .tick     (tick_us),
    .expire   (span_exp)
  );

  phc_tick_timer #(.W(PT_W)) u_pt_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (tmr_clr),
    .load     (pt_load),
    .load_val (pt_len),
    .tick     (tick_us),
    .expire   (pt_exp)
  );

  phc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .cmd_on     (cmd_on),
    .mode_in    (mode_e),
    .cmp_peak   (cmp_peak),
    .cmp_hold   (cmp_hold),
    .span_exp   (span_exp),
    .pt_exp     (pt_exp),
    .ph_q       (ph_q),
    .use_peak_q (use_peak_q),
    .span_load  (span_load),
    .span_off   (span_off),
    .pt_load    (pt_load),
    .tmr_clr    (tmr_clr)
  );

  assign gate_en      = (ph_q == PH_FOLLOW) || (ph_q == PH_BLANK) || (ph_q == PH_CONDUCT);
  assign thr_peak_sel = use_peak_q;
  assign thr_code     = use_peak_q ? pk_code : hd_code;
  assign phase        = ph_q;

endmodule

// File: rtl/pkhold_ctrl_chk.sv
module pkhold_ctrl_chk
  import phc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_on,
  input logic       tick_us,
  input logic [1:0] mode_sel,
  input logic       cmp_peak,
  input logic       cmp_hold,
  input logic       gate_en,
  input logic       thr_peak_sel,
  input logic [2:0] phase
);

  assert_drop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> (phase == PH_IDLE) && !gate_en && thr_peak_sel);

  assert_follow_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) && cmd_on && (mode_sel == 2'b00) |=> (phase == PH_FOLLOW) && gate_en);

  assert_wake_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) && cmd_on && (mode_sel != 2'b00) |=> (phase == PH_BLANK) && gate_en);

  assert_hit_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONDUCT) && cmd_on && (thr_peak_sel ? cmp_peak : cmp_hold)
    |=> (phase == PH_REST) && !gate_en);

  assert_blank_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BLANK) && cmd_on && !tick_us |=> (phase == PH_BLANK));

  assert_rest_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REST) && cmd_on && !tick_us |=> (phase == PH_REST));

  assert_hold_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on && (phase != PH_IDLE) && !thr_peak_sel |=> !thr_peak_sel);

  assert_follow_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on && (phase == PH_FOLLOW) |=> (phase == PH_FOLLOW));

endmodule

bind pkhold_ctrl pkhold_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_on       (cmd_on),
  .tick_us      (tick_us),
  .mode_sel     (mode_sel),
  .cmp_peak     (cmp_peak),
  .cmp_hold     (cmp_hold),
  .gate_en      (gate_en),
  .thr_peak_sel (thr_peak_sel),
  .phase        (phase)
);

// File: tb/pkhold_ctrl_tb.sv
`timescale 1ns/1ps
module pkhold_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_on;
  logic       tick_us;
  logic [1:0] mode_sel;
  logic [1:0] pk_code;
  logic [1:0] hd_code;
  logic [1:0] off_code;
  logic [2:0] ptime_code;
  logic       cmp_peak = 1'b0;
  logic       cmp_hold = 1'b0;
  logic       gate_en;
  logic       thr_peak_sel;
  logic [1:0] thr_code;
  logic [2:0] phase;

  always #2 clk = ~clk;

  pkhold_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_on       (cmd_on),
    .tick_us      (tick_us),
    .mode_sel     (mode_sel),
    .pk_code      (pk_code),
    .hd_code      (hd_code),
    .off_code     (off_code),
    .ptime_code   (ptime_code),
    .cmp_peak     (cmp_peak),
    .cmp_hold     (cmp_hold),
    .gate_en      (gate_en),
    .thr_peak_sel (thr_peak_sel),
    .thr_code     (thr_code),
    .phase        (phase)
  );

  int vectors     = 0;
  int miscompares = 0;
  bit done        = 1'b0;

  // Scoreboard of expected gate runs (level, length, threshold at run end)
  bit    q_lvl[$];
  int    q_len[$];
  bit    q_chk[$];
  bit    q_sel[$];
  int    q_code[$];
  string q_tag[$];

  task automatic push_run(input bit lvl, input int len, input bit chk,
                          input bit sel, input int code, input string tag);
    q_lvl.push_back(lvl);
    q_len.push_back(len);
    q_chk.push_back(chk);
    q_sel.push_back(sel);
    q_code.push_back(code);
    q_tag.push_back(tag);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Load model: comparator asserts once the gate has been on for dp / dh samples
  int hi_cnt = 0;
  int dp     = 1;
  int dh     = 1;

  always @(negedge clk) begin
    hi_cnt   = gate_en ? hi_cnt + 1 : 0;
    cmp_peak = (hi_cnt > 0) && (hi_cnt >= dp);
    cmp_hold = (hi_cnt > 0) && (hi_cnt >= dh);
  end

  // Monitor: measures gate runs and compares them with the scoreboard
  bit mon_en   = 1'b0;
  bit prev_g   = 1'b0;
  int run_len  = 0;
  bit last_sel = 1'b0;
  int last_code = 0;

  always @(negedge clk) begin
    if (!mon_en) begin
      prev_g  = gate_en;
      run_len = 1;
    end else if (gate_en == prev_g) begin
      run_len++;
    end else begin
      vectors++;
      if (q_lvl.size() == 0) begin
        miscompares++;
        $display("FAIL R3 unexpected run actual lvl=%0d len=%0d expected none", prev_g, run_len);
      end else begin
        bit    e_lvl;
        int    e_len;
        bit    e_chk;
        bit    e_sel;
        int    e_code;
        string e_tag;
        e_lvl  = q_lvl.pop_front();
        e_len  = q_len.pop_front();
        e_chk  = q_chk.pop_front();
        e_sel  = q_sel.pop_front();
        e_code = q_code.pop_front();
        e_tag  = q_tag.pop_front();
        if ((e_lvl != prev_g) || ((e_len >= 0) && (e_len != run_len)) ||
            (e_chk && ((e_sel != last_sel) || (e_code != last_code)))) begin
          miscompares++;
          $display("FAIL %s run actual lvl=%0d len=%0d sel=%0d code=%0d expected lvl=%0d len=%0d sel=%0d code=%0d",
                   e_tag, prev_g, run_len, last_sel, last_code, e_lvl, e_len, e_sel, e_code);
        end
      end
      run_len = 1;
      prev_g  = gate_en;
    end
    last_sel  = thr_peak_sel;
    last_code = int'(thr_code);
  end

  // Waits for the last regulated run, then drops the command during conduction
  task automatic finish_run();
    while (q_lvl.size() > 2) @(negedge clk);
    @(negedge clk);
    cmd_on = 1'b0;
    @(negedge clk);
    check("R7 gate after drop", int'(gate_en), 0);
    check("R7 phase after drop", int'(phase), 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cmd_on     = 1'b0;
    tick_us    = 1'b1;
    mode_sel   = 2'b00;
    pk_code    = 2'd2;
    hd_code    = 2'd1;
    off_code   = 2'd1;
    ptime_code = 3'd5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("R10 gate", int'(gate_en), 0);
    check("R10 phase", int'(phase), 0);
    check("R10 sel", int'(thr_peak_sel), 1);
    check("R10 code", int'(thr_code), int'(pk_code));

    push_run(1'b0, -1, 1'b0, 1'b0, 0, "R10");
    mon_en = 1'b1;
    @(negedge clk);

    // R1: follow scheme, gate mirrors command with one clock lag
    mode_sel = 2'b00;
    push_run(1'b1, 37, 1'b0, 1'b0, 0, "R1");
    push_run(1'b0, -1, 1'b0, 1'b0, 0, "R1");
    cmd_on = 1'b1;
    @(negedge clk);
    check("R1 phase follow", int'(phase), 1);
    repeat (36) @(negedge clk);
    cmd_on = 1'b0;
    @(negedge clk);
    check("R7 gate after follow", int'(gate_en), 0);
    repeat (5) @(negedge clk);

    // R2 R4 R9: hold only, early comparator blanked, scheme change ignored
    mode_sel = 2'b01; pk_code = 2'd2; hd_code = 2'd1; off_code = 2'd1;
    dp = 5; dh = 5;
    push_run(1'b1, 21,  1'b1, 1'b0, 1, "R4");
    push_run(1'b0, 200, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, 21,  1'b1, 1'b0, 1, "R2");
    push_run(1'b0, 200, 1'b0, 1'b0, 0, "R9");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R9");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R9");
    cmd_on = 1'b1;
    @(negedge clk);
    check("R2 phase blank", int'(phase), 2);
    check("R4 hold selected", int'(thr_peak_sel), 0);
    mode_sel = 2'b00;
    finish_run();

    // R5: single peak hit then hold, 400 tick rest
    mode_sel = 2'b10; pk_code = 2'd3; hd_code = 2'd0; off_code = 2'd3;
    dp = 60; dh = 40;
    push_run(1'b1, 60,  1'b1, 1'b1, 3, "R5");
    push_run(1'b0, 400, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, 40,  1'b1, 1'b0, 0, "R5");
    push_run(1'b0, 400, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, 40,  1'b1, 1'b0, 0, "R5");
    push_run(1'b0, 400, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R5");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R5");
    cmd_on = 1'b1;
    finish_run();

    // R6: timed peak of 800 ticks, expiry inside a rest phase
    mode_sel = 2'b11; pk_code = 2'd1; hd_code = 2'd2; off_code = 2'd0; ptime_code = 3'd0;
    dp = 21; dh = 30;
    for (int k = 0; k < 7; k++) begin
      push_run(1'b1, 21,  1'b1, 1'b1, 1, "R6");
      push_run(1'b0, 100, 1'b0, 1'b0, 0, "R6");
    end
    push_run(1'b1, 30,  1'b1, 1'b0, 2, "R6");
    push_run(1'b0, 100, 1'b0, 1'b0, 0, "R6");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R6");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R6");
    cmd_on = 1'b1;
    finish_run();

    // R6: expiry coincides with a peak hit on tick 800
    mode_sel = 2'b11; pk_code = 2'd3; hd_code = 2'd1; off_code = 2'd0; ptime_code = 3'd0;
    dp = 200; dh = 30;
    for (int k = 0; k < 3; k++) begin
      push_run(1'b1, 200, 1'b1, 1'b1, 3, "R6 coincide");
      push_run(1'b0, 100, 1'b0, 1'b0, 0, "R6 coincide");
    end
    push_run(1'b1, 30,  1'b1, 1'b0, 1, "R6 coincide");
    push_run(1'b0, 100, 1'b0, 1'b0, 0, "R6 coincide");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R6");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R6");
    cmd_on = 1'b1;
    finish_run();

    // R8: no tick for 300 clocks stretches blanking
    mode_sel = 2'b01; hd_code = 2'd3; off_code = 2'd2;
    dp = 1; dh = 1;
    push_run(1'b1, 320, 1'b1, 1'b0, 3, "R8");
    push_run(1'b0, 300, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R8");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R8");
    tick_us = 1'b0;
    cmd_on  = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 phase stalled blank", int'(phase), 2);
    check("R8 gate on in blank", int'(gate_en), 1);
    repeat (295) @(negedge clk);
    tick_us = 1'b1;
    finish_run();

    // R7: drop during rest, restart begins again from peak with full blank
    mode_sel = 2'b10; pk_code = 2'd0; hd_code = 2'd3; off_code = 2'd0;
    dp = 21; dh = 21;
    push_run(1'b1, 21,  1'b1, 1'b1, 0, "R7");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R7");
    push_run(1'b1, 21,  1'b1, 1'b1, 0, "R7 restart");
    push_run(1'b0, 100, 1'b0, 1'b0, 0, "R3");
    push_run(1'b1, -1,  1'b0, 1'b0, 0, "R7");
    push_run(1'b0, -1,  1'b0, 1'b0, 0, "R7");
    cmd_on = 1'b1;
    while (q_lvl.size() > 5) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R7 phase rest before drop", int'(phase), 4);
    cmd_on = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 peak reselected in idle", int'(thr_peak_sel), 1);
    cmd_on = 1'b1;
    finish_run();

    check("R7 scoreboard drained", q_lvl.size(), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule